// File: doc/BRIEF.md
# Serial-to-Parallel Shift Register with Holding Stage

This block turns a serial bit stream into a parallel word. A chain of flip-flops takes one new bit on each rising edge of a shift clock. A separate holding register copies the whole chain on each rising edge of a second clock, so the parallel outputs change only when the holding register is loaded, no matter how many bits have been shifted in since.

Each of the two registers has its own clock and its own active-low clear. A clear acts at once, without waiting for a clock edge. The last stage of the chain is brought out directly as a cascade output. Several instances can therefore be chained: the cascade output of one drives the serial input of the next, and a single load pulse on the shared holding clock captures a word that is several instances wide. The parallel outputs always show the holding register. There is no output-enable control.

Top module: `sipo_latch_out`

## Requirements
- R1: On each rising edge of `shift_clk` with `shift_clr_n` high, stage 0 takes `ser_in` and stage i takes the old value of stage i-1. Stage i is the bit that `par_out[i]` later shows.
- R2: While `shift_clr_n` is low, every shift stage is 0. This takes effect as soon as the clear falls, and the clear wins over any `shift_clk` edge or `ser_in` value.
- R3: While `store_clr_n` is low, `par_out` is all zeros. This takes effect as soon as the clear falls, and the shift stages keep their values.
- R4: On a rising edge of `store_clk` with `store_clr_n` high, `par_out` takes the shift-stage values as they were just before that edge.
- R5: When there is no `shift_clk` edge and no shift clear, the shift stages hold their values, even across `store_clk` edges.
- R6: When there is no `store_clk` edge and no storage clear, `par_out` holds its value, even across `shift_clk` edges.
- R7: `cascade_out` always equals the last shift stage, with no further register in between.
- R8: When `shift_clk` and `store_clk` rise together, `par_out` shows the chain as it was one shift pulse earlier. For example, after a clear and three tied pulses with `ser_in` high, `par_out` is 8'h03.
- R9: With two 8-bit instances chained through `cascade_out`, suppose 16 bits of a word are shifted in MSB first and then one `store_clk` edge follows. The downstream instance then shows the upper byte and the upstream instance shows the lower byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ser_in | input | 1 | Serial data into stage 0 |
| shift_clk | input | 1 | Shift clock, rising-edge active |
| shift_clr_n | input | 1 | Asynchronous clear of the shift stages, active low |
| store_clk | input | 1 | Holding-register load clock, rising-edge active |
| store_clr_n | input | 1 | Asynchronous clear of the holding register, active low |
| par_out | output | WIDTH | Holding register contents |
| cascade_out | output | 1 | Last shift stage, for chaining |

## Verification
The assertions assume that `ser_in` and both clears are stable around a rising edge of either clock. In particular, a clear never falls or rises at the same instant as a clock edge. If it did, the value sampled at that edge would be ambiguous. The stimulus changes `ser_in` half a bench period before any clock edge, and it moves the clears only at instants where both register clocks are low and not about to rise. The transfer and shift checks are gated so that they begin only after one edge has been seen since the last clear.

// File: rtl/sipo_pkg.sv
package sipo_pkg;
    localparam int unsigned DEF_WIDTH = 8;

    // Stage index at which the cascade tap sits for a given width
    function automatic int unsigned tap_index(input int unsigned width);
        return width - 1;
    endfunction
endpackage

// File: rtl/sipo_shift_chain.sv
module sipo_shift_chain #(
    parameter int unsigned WIDTH = sipo_pkg::DEF_WIDTH
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic             din,
    output logic [WIDTH-1:0] stages
);
    logic [WIDTH-1:0] feed;

    assign feed[0] = din;

    generate
        for (genvar i = 1; i < WIDTH; i++) begin : g_link
            assign feed[i] = stages[i-1];
        end
        for (genvar i = 0; i < WIDTH; i++) begin : g_stage
            always_ff @(posedge clk or negedge clr_n) begin
                if (!clr_n) stages[i] <= 1'b0;
                else        stages[i] <= feed[i];
            end
        end
    endgenerate
endmodule

// File: rtl/sipo_hold_reg.sv
module sipo_hold_reg #(
    parameter int unsigned WIDTH = sipo_pkg::DEF_WIDTH
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            always_ff @(posedge clk or negedge clr_n) begin
                if (!clr_n) q[i] <= 1'b0;
                else        q[i] <= d[i];
            end
        end
    endgenerate
endmodule

// File: rtl/sipo_latch_out.sv
module sipo_latch_out #(
    parameter int unsigned WIDTH = sipo_pkg::DEF_WIDTH
) (
    input  logic             ser_in,
    input  logic             shift_clk,
    input  logic             shift_clr_n,
    input  logic             store_clk,
    input  logic             store_clr_n,
    output logic [WIDTH-1:0] par_out,
    output logic             cascade_out
);
    localparam int unsigned TAP = sipo_pkg::tap_index(WIDTH);

    logic [WIDTH-1:0] shift_q;

    sipo_shift_chain #(.WIDTH(WIDTH)) u_chain (
        .clk    (shift_clk),
        .clr_n  (shift_clr_n),
        .din    (ser_in),
        .stages (shift_q)
    );

    sipo_hold_reg #(.WIDTH(WIDTH)) u_hold (
        .clk   (store_clk),
        .clr_n (store_clr_n),
        .d     (shift_q),
        .q     (par_out)
    );

    assign cascade_out = shift_q[TAP];
endmodule

// File: rtl/sipo_latch_out_chk.sv
module sipo_latch_out_chk #(
    parameter int unsigned WIDTH = sipo_pkg::DEF_WIDTH
) (
    input logic             ser_in,
    input logic             shift_clk,
    input logic             shift_clr_n,
    input logic             store_clk,
    input logic             store_clr_n,
    input logic [WIDTH-1:0] par_out,
    input logic [WIDTH-1:0] shift_q
);
    logic sh_seen;
    logic st_seen;

    always_ff @(posedge shift_clk or negedge shift_clr_n) begin
        if (!shift_clr_n) sh_seen <= 1'b0;
        else              sh_seen <= 1'b1;
    end

    always_ff @(posedge store_clk or negedge store_clr_n) begin
        if (!store_clr_n) st_seen <= 1'b0;
        else              st_seen <= 1'b1;
    end

    assert_shift_step_R1: assert property (@(posedge shift_clk) disable iff (!shift_clr_n)
        sh_seen |-> (shift_q[WIDTH-1:1] == $past(shift_q[WIDTH-2:0]))
                    && (shift_q[0] == $past(ser_in)));

    assert_shift_clear_R2: assert property (@(posedge shift_clk)
        !shift_clr_n |-> (shift_q == '0));

    assert_store_clear_R3: assert property (@(posedge store_clk)
        !store_clr_n |-> (par_out == '0));

    assert_transfer_R4: assert property (@(posedge store_clk) disable iff (!store_clr_n)
        st_seen |-> (par_out == $past(shift_q)));
endmodule

bind sipo_latch_out sipo_latch_out_chk #(.WIDTH(WIDTH)) u_chk (
    .ser_in      (ser_in),
    .shift_clk   (shift_clk),
    .shift_clr_n (shift_clr_n),
    .store_clk   (store_clk),
    .store_clr_n (store_clr_n),
    .par_out     (par_out),
    .shift_q     (shift_q)
);

// File: tb/sipo_latch_out_tb.sv
`timescale 1ns/1ps
module sipo_latch_out_tb;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic ser_in = 1'b0;
    logic shift_clk = 1'b0, store_clk = 1'b0;
    logic shift_clr_n = 1'b0, store_clr_n = 1'b0;
    logic [7:0] par_lo, par_hi;
    logic casc_lo, casc_hi;

    int n_chk = 0;
    int n_fail = 0;

    // Reference: bit 0 = first stage of upstream device, bit 15 = last of downstream
    logic [15:0] m_sh = '0;
    logic [15:0] m_st = '0;

    sipo_latch_out #(.WIDTH(8)) u_dut (
        .ser_in(ser_in), .shift_clk(shift_clk), .shift_clr_n(shift_clr_n),
        .store_clk(store_clk), .store_clr_n(store_clr_n),
        .par_out(par_lo), .cascade_out(casc_lo));

    sipo_latch_out #(.WIDTH(8)) u_dut_hi (
        .ser_in(casc_lo), .shift_clk(shift_clk), .shift_clr_n(shift_clr_n),
        .store_clk(store_clk), .store_clr_n(store_clr_n),
        .par_out(par_hi), .cascade_out(casc_hi));

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic compare_all();
        chk("R4 R6 holding register", {par_hi, par_lo}, m_st);
        chk("R1 R5 R7 cascade taps", {14'd0, casc_hi, casc_lo}, {14'd0, m_sh[15], m_sh[7]});
    endtask

    task automatic step(input logic sh, input logic st, input logic d);
        @(negedge clk);
        ser_in = d;
        @(posedge clk);
        #2;
        shift_clk = sh;
        store_clk = st;
        if (st && store_clr_n) m_st = m_sh;
        if (sh && shift_clr_n) m_sh = {m_sh[14:0], d};
        #6;
        shift_clk = 1'b0;
        store_clk = 1'b0;
        #2;
        compare_all();
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(200000 * 20);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [15:0] word;
        logic [15:0] lfsr;
        #25;
        // R2 R3: clears held from time zero
        chk("R2 R3 reset state", {par_hi, par_lo}, 16'h0000);
        chk("R2 reset cascade", {14'd0, casc_hi, casc_lo}, 16'h0000);
        @(negedge clk);
        shift_clr_n = 1'b1;
        store_clr_n = 1'b1;

        // R9: 16 bits MSB first through the chained pair, then one load
        word = 16'hA5C3;
        for (int i = 15; i >= 0; i--) step(1'b1, 1'b0, word[i]);
        step(1'b0, 1'b1, 1'b0);
        chk("R9 chained upper byte", {8'd0, par_hi}, {8'd0, word[15:8]});
        chk("R9 chained lower byte", {8'd0, par_lo}, {8'd0, word[7:0]});

        // R6: shifting without load leaves outputs alone
        step(1'b1, 1'b0, 1'b1);
        step(1'b1, 1'b0, 1'b0);
        step(1'b1, 1'b0, 1'b1);
        chk("R6 outputs unchanged by shifts", {par_hi, par_lo}, word);
        // R5: loads without shifts leave the chain alone
        step(1'b0, 1'b1, 1'b0);
        step(1'b0, 1'b1, 1'b1);

        // R3: async storage clear, chain untouched
        @(negedge clk);
        #3;
        store_clr_n = 1'b0;
        m_st = '0;
        #2;
        chk("R3 immediate storage clear", {par_hi, par_lo}, 16'h0000);
        chk("R3 chain kept through storage clear", {14'd0, casc_hi, casc_lo},
            {14'd0, m_sh[15], m_sh[7]});
        step(1'b0, 1'b1, 1'b0);
        chk("R3 clear wins over load edge", {par_hi, par_lo}, 16'h0000);
        @(negedge clk);
        store_clr_n = 1'b1;
        step(1'b0, 1'b1, 1'b0);
        chk("R3 chain contents intact after clear", {par_hi, par_lo}, m_sh);

        // R2: async shift clear, priority over shift edges
        word = {par_hi, par_lo};
        @(negedge clk);
        #3;
        shift_clr_n = 1'b0;
        m_sh = '0;
        #2;
        chk("R2 immediate shift clear", {14'd0, casc_hi, casc_lo}, 16'h0000);
        chk("R6 outputs kept through shift clear", {par_hi, par_lo}, word);
        step(1'b1, 1'b0, 1'b1);
        step(1'b1, 1'b0, 1'b1);
        @(negedge clk);
        shift_clr_n = 1'b1;
        step(1'b0, 1'b1, 1'b0);
        chk("R2 clear wins over shift edges", {par_hi, par_lo}, 16'h0000);

        // R8: tied clocks, holding lags one pulse
        step(1'b1, 1'b1, 1'b1);
        step(1'b1, 1'b1, 1'b1);
        step(1'b1, 1'b1, 1'b1);
        chk("R8 tied clocks one pulse lag", {8'd0, par_lo}, 16'h0003);

        // Mixed pattern against the reference
        lfsr = 16'hACE1;
        for (int i = 0; i < 60; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[0] | lfsr[3], lfsr[5] & lfsr[1], lfsr[7]);
        end

        finish_run();
    end
endmodule